// File: doc/BRIEF.md
# Linear CCD Readout Timing Generator

This block derives every digital drive pulse of a four-output linear CCD image sensor from one system clock. Each line starts with a transfer window: the phase-1 clock is parked in its transfer state, the shift-gate pulse moves charge from the photodiodes into the analog shift registers, and the reset and clamp pulses are held off. A readout of a fixed number of pixel periods follows. In each period the two transfer phases toggle in opposition, the last-stage clock tracks phase 2, one reset pulse and then one clamp pulse are issued, and an ADC sample strobe with the pixel index marks the settled video level. All four outputs are read in parallel, so one pixel period serves all four channels.

The time between successive shift-gate pulses is the integration time. It is taken from the `integ_len` input at each line boundary and is never shorter than one transfer window plus one full readout. Any time left over after the readout is filled with flush clocking: the transfer clocks and the reset and clamp pulses keep running, but no pixel is flagged valid. Every pulse position is a parameter counted in system-clock cycles. All outputs are registered. A synchronous reset drives them all low.

Top module: `ccdtg_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, every output is 0 and `pixel_index` is 0. The first line after reset begins with a transfer window.
- R2: A line opens with a transfer window of LEAD+SH_WIDTH+TRAIL cycles, where LEAD = max(SH_LEAD, GUARD) and TRAIL = max(SH_TRAIL, GUARD). During this window `phi1` is 1 and `phi2` and `phi2_last` are 0. `sh_gate` is 1 for exactly SH_WIDTH cycles, starting LEAD cycles into the window.
- R3: `rs_gate` and `cp_gate` are 0 throughout the transfer window. At least GUARD cycles of inactivity separate them from the `sh_gate` pulse on either side.
- R4: Outside the transfer window, with s the cycle number inside the pixel period (0..PIX_CYC-1), `phi2` is 1 for s < PIX_CYC/2 and 0 otherwise. `phi1` is always the complement of `phi2`, and `phi2_last` equals `phi2`.
- R5: `rs_gate` is 1 exactly when RS_OFS <= s < RS_OFS+RS_WIDTH, so there is one reset pulse in every pixel period.
- R6: `cp_gate` is 1 exactly when CP_OFS <= s < CP_OFS+CP_WIDTH. It rises only after `rs_gate` has fallen.
- R7: During readout, `adc_sample` pulses once per pixel at s == SMP_OFS. `pixel_index` counts 0..NPIX-1 across the readout and is 0 outside it.
- R8: `line_valid` is 1 for exactly NPIX*PIX_CYC cycles, directly after the transfer window. `line_start` is a single-cycle pulse on the first of these cycles.
- R9: The line period, measured between successive `line_start` pulses, equals `integ_len` sampled at the line boundary. It is raised to LEAD+SH_WIDTH+TRAIL+NPIX*PIX_CYC when `integ_len` is below that value.
- R10: Between the end of readout and the end of the line period, the clock, reset and clamp pattern of R4 to R6 continues, while `line_valid`, `adc_sample` and `line_start` stay 0.
- R11: A change of `integ_len` during a line has no effect on the length of that line. It takes effect from the next line boundary onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| integ_len | input | LEN_W | Requested line period (integration time) in clock cycles |
| sh_gate | output | 1 | Shift-gate pulse |
| phi1 | output | 1 | Transfer clock phase 1 |
| phi2 | output | 1 | Transfer clock phase 2 |
| phi2_last | output | 1 | Last-stage clock, follows phase 2 |
| rs_gate | output | 1 | Output-node reset pulse |
| cp_gate | output | 1 | Clamp pulse |
| line_start | output | 1 | One-cycle strobe at the start of readout |
| line_valid | output | 1 | High while valid pixels are read out |
| adc_sample | output | 1 | ADC sample strobe, once per valid pixel |
| pixel_index | output | IDX_W | Index of the pixel being read out |

## Verification
The bench builds the block with five pixels per line, an eight-cycle pixel period and a shift-gate lead and trail of three cycles around a four-cycle pulse, with a guard of two. The minimum line period is therefore 50 cycles, and many full lines, clamped periods, flush intervals and line boundaries fit into a few hundred cycles. The bench drives `integ_len` below, at and above the minimum and changes it in the middle of lines. It also resets the block mid-line. Each cycle's outputs are compared with a behavioural model built on absolute line positions, and the spacing between `line_start` pulses is checked against the period each line should have had.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  typedef enum logic [1:0] {
    PH_XFER  = 2'd0,
    PH_READ  = 2'd1,
    PH_FLUSH = 2'd2
  } phase_e;

  typedef struct packed {
    logic sh;
    logic phi1;
    logic phi2;
    logic phi2l;
    logic rs;
    logic cp;
    logic lstart;
    logic lval;
    logic smp;
  } drive_t;

endpackage

// File: rtl/ccdtg_line_seq.sv
module ccdtg_line_seq
  import ccdtg_pkg::*;
#(
  parameter int LEN_W    = 24,
  parameter int XFER_LEN = 350,
  parameter int READ_LEN = 15512,
  parameter int SH_START = 100,
  parameter int SH_END   = 250,
  localparam int MIN_LEN = XFER_LEN + READ_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] integ_len,
  output phase_e           phase,
  output logic             sh_on
);

  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] len_req;
  logic [31:0]      pos32;
  logic             at_end;

  assign pos32  = 32'(pos);
  assign at_end = (pos32 == (32'(cur_len) - 32'd1));

  // integration period never shorter than transfer plus full readout
  always_comb begin
    if (32'(integ_len) < 32'(MIN_LEN)) len_req = LEN_W'(MIN_LEN);
    else                               len_req = integ_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      cur_len <= len_req;
    end else if (at_end) begin
      pos     <= '0;
      cur_len <= len_req;
    end else begin
      pos     <= pos + 1'b1;
    end
  end

  always_comb begin
    if (pos32 < 32'(XFER_LEN))                   phase = PH_XFER;
    else if (pos32 < 32'(XFER_LEN + READ_LEN))   phase = PH_READ;
    else                                         phase = PH_FLUSH;
  end

  assign sh_on = (pos32 >= 32'(SH_START)) && (pos32 < 32'(SH_END));

endmodule

// File: rtl/ccdtg_pix_seq.sv
module ccdtg_pix_seq
  import ccdtg_pkg::*;
#(
  parameter int PIX_CYC = 8,
  parameter int NPIX    = 1939,
  localparam int SUB_W  = (PIX_CYC > 1) ? $clog2(PIX_CYC) : 1,
  localparam int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  output logic [SUB_W-1:0] sub,
  output logic [IDX_W-1:0] idx
);

  logic sub_wrap;
  assign sub_wrap = (32'(sub) == 32'(PIX_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || phase == PH_XFER) begin
      sub <= '0;
      idx <= '0;
    end else begin
      sub <= sub_wrap ? '0 : sub + 1'b1;
      if (phase == PH_READ && sub_wrap && (32'(idx) < 32'(NPIX - 1)))
        idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/ccdtg_pulse_fmt.sv
module ccdtg_pulse_fmt
  import ccdtg_pkg::*;
#(
  parameter int PIX_CYC  = 8,
  parameter int NPIX     = 1939,
  parameter int RS_OFS   = 0,
  parameter int RS_WIDTH = 1,
  parameter int CP_OFS   = 2,
  parameter int CP_WIDTH = 2,
  parameter int SMP_OFS  = 6,
  localparam int SUB_W   = (PIX_CYC > 1) ? $clog2(PIX_CYC) : 1,
  localparam int IDX_W   = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int HALF    = PIX_CYC / 2
) (
  input  phase_e           phase,
  input  logic             sh_on,
  input  logic [SUB_W-1:0] sub,
  input  logic [IDX_W-1:0] idx,
  output drive_t           drv
);

  logic [31:0] s32;
  assign s32 = 32'(sub);

  always_comb begin
    drv = '0;
    if (phase == PH_XFER) begin
      drv.phi1 = 1'b1;
      drv.sh   = sh_on;
    end else begin
      drv.phi2  = (s32 < 32'(HALF));
      drv.phi1  = !drv.phi2;
      drv.phi2l = drv.phi2;
      drv.rs    = (s32 >= 32'(RS_OFS)) && (s32 < 32'(RS_OFS + RS_WIDTH));
      drv.cp    = (s32 >= 32'(CP_OFS)) && (s32 < 32'(CP_OFS + CP_WIDTH));
      if (phase == PH_READ) begin
        drv.lval   = 1'b1;
        drv.smp    = (s32 == 32'(SMP_OFS));
        drv.lstart = (s32 == 32'd0) && (idx == '0);
      end
    end
  end

endmodule

// File: rtl/ccdtg_top.sv
module ccdtg_top
  import ccdtg_pkg::*;
#(
  parameter int NPIX      = 1939,
  parameter int PIX_CYC   = 8,
  parameter int SH_LEAD   = 100,
  parameter int SH_WIDTH  = 150,
  parameter int SH_TRAIL  = 100,
  parameter int GUARD     = 20,
  parameter int RS_OFS    = 0,
  parameter int RS_WIDTH  = 1,
  parameter int CP_OFS    = 2,
  parameter int CP_WIDTH  = 2,
  parameter int SMP_OFS   = 6,
  parameter int LEN_W     = 24,
  localparam int IDX_W    = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] integ_len,
  output logic             sh_gate,
  output logic             phi1,
  output logic             phi2,
  output logic             phi2_last,
  output logic             rs_gate,
  output logic             cp_gate,
  output logic             line_start,
  output logic             line_valid,
  output logic             adc_sample,
  output logic [IDX_W-1:0] pixel_index
);

  localparam int LEAD_EFF  = (SH_LEAD  > GUARD) ? SH_LEAD  : GUARD;
  localparam int TRAIL_EFF = (SH_TRAIL > GUARD) ? SH_TRAIL : GUARD;
  localparam int XFER_LEN  = LEAD_EFF + SH_WIDTH + TRAIL_EFF;
  localparam int READ_LEN  = NPIX * PIX_CYC;
  localparam int SUB_W     = (PIX_CYC > 1) ? $clog2(PIX_CYC) : 1;

  phase_e           phase;
  logic             sh_on;
  logic [SUB_W-1:0] sub;
  logic [IDX_W-1:0] idx;
  drive_t           drv_nxt;
  drive_t           drv_q;
  logic [IDX_W-1:0] idx_q;

  ccdtg_line_seq #(
    .LEN_W    (LEN_W),
    .XFER_LEN (XFER_LEN),
    .READ_LEN (READ_LEN),
    .SH_START (LEAD_EFF),
    .SH_END   (LEAD_EFF + SH_WIDTH)
  ) u_line (
    .clk       (clk),
    .rst       (rst),
    .integ_len (integ_len),
    .phase     (phase),
    .sh_on     (sh_on)
  );

  ccdtg_pix_seq #(
    .PIX_CYC (PIX_CYC),
    .NPIX    (NPIX)
  ) u_pix (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .sub   (sub),
    .idx   (idx)
  );

  ccdtg_pulse_fmt #(
    .PIX_CYC  (PIX_CYC),
    .NPIX     (NPIX),
    .RS_OFS   (RS_OFS),
    .RS_WIDTH (RS_WIDTH),
    .CP_OFS   (CP_OFS),
    .CP_WIDTH (CP_WIDTH),
    .SMP_OFS  (SMP_OFS)
  ) u_fmt (
    .phase (phase),
    .sh_on (sh_on),
    .sub   (sub),
    .idx   (idx),
    .drv   (drv_nxt)
  );

  // registered drive stage: glitch-free pulses toward the clock drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '0;
      idx_q <= '0;
    end else begin
      drv_q <= drv_nxt;
      idx_q <= drv_nxt.lval ? idx : '0;
    end
  end

  assign sh_gate     = drv_q.sh;
  assign phi1        = drv_q.phi1;
  assign phi2        = drv_q.phi2;
  assign phi2_last   = drv_q.phi2l;
  assign rs_gate     = drv_q.rs;
  assign cp_gate     = drv_q.cp;
  assign line_start  = drv_q.lstart;
  assign line_valid  = drv_q.lval;
  assign adc_sample  = drv_q.smp;
  assign pixel_index = idx_q;

endmodule

// File: rtl/ccdtg_chk.sv
module ccdtg_chk #(
  parameter int GUARD = 20
) (
  input logic clk,
  input logic rst,
  input logic sh_gate,
  input logic phi1,
  input logic phi2,
  input logic rs_gate,
  input logic cp_gate,
  input logic line_start,
  input logic line_valid,
  input logic adc_sample
);

  logic        armed;
  logic [15:0] gap_rc;
  logic [15:0] gap_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      gap_rc <= 16'hFFFF;
      gap_sh <= 16'hFFFF;
    end else begin
      armed  <= 1'b1;
      gap_rc <= (rs_gate || cp_gate) ? 16'd0 : ((gap_rc == 16'hFFFF) ? gap_rc : gap_rc + 16'd1);
      gap_sh <= sh_gate ? 16'd0 : ((gap_sh == 16'hFFFF) ? gap_sh : gap_sh + 16'd1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !(sh_gate || phi1 || phi2 || rs_gate || cp_gate || line_valid || adc_sample)); // R1

  AST_SH_PHI1_PARK: assert property (@(posedge clk) disable iff (rst)
    sh_gate |-> phi1 && !phi2); // R2

  AST_SH_NO_RS_CP: assert property (@(posedge clk) disable iff (rst)
    sh_gate |-> !rs_gate && !cp_gate); // R3

  AST_GUARD_BEFORE_SH: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(sh_gate)) |-> (32'(gap_rc) >= 32'(GUARD))); // R3

  AST_GUARD_AFTER_SH: assert property (@(posedge clk) disable iff (rst)
    (armed && ($rose(rs_gate) || $rose(cp_gate))) |-> (32'(gap_sh) >= 32'(GUARD))); // R3

  AST_PHASE_COMPL: assert property (@(posedge clk) disable iff (rst)
    armed |-> (phi1 != phi2)); // R4

  AST_CP_AFTER_RS: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(cp_gate)) |-> !rs_gate); // R6

  AST_SAMPLE_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    adc_sample |-> line_valid); // R7

  AST_LSTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start); // R8

endmodule

bind ccdtg_top ccdtg_chk #(.GUARD(GUARD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sh_gate    (sh_gate),
  .phi1       (phi1),
  .phi2       (phi2),
  .rs_gate    (rs_gate),
  .cp_gate    (cp_gate),
  .line_start (line_start),
  .line_valid (line_valid),
  .adc_sample (adc_sample)
);

// File: tb/ccdtg_top_test.sv
`timescale 1ns/1ps
module ccdtg_top_test;

  localparam int NPIX = 5, PC = 8, LEAD = 3, SHW = 4, TRAIL = 3, GRD = 2;
  localparam int RSO = 0, RSW = 1, CPO = 2, CPW = 2, SMO = 6, LW = 16;
  localparam int XFER = LEAD + SHW + TRAIL;
  localparam int MINL = XFER + NPIX * PC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] integ_len = '0;
  logic sh_gate, phi1, phi2, phi2_last, rs_gate, cp_gate;
  logic line_start, line_valid, adc_sample;
  logic [2:0] pixel_index;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccdtg_top #(
    .NPIX(NPIX), .PIX_CYC(PC), .SH_LEAD(LEAD), .SH_WIDTH(SHW), .SH_TRAIL(TRAIL),
    .GUARD(GRD), .RS_OFS(RSO), .RS_WIDTH(RSW), .CP_OFS(CPO), .CP_WIDTH(CPW),
    .SMP_OFS(SMO), .LEN_W(LW)
  ) uut (
    .clk(clk), .rst(rst), .integ_len(integ_len), .sh_gate(sh_gate), .phi1(phi1),
    .phi2(phi2), .phi2_last(phi2_last), .rs_gate(rs_gate), .cp_gate(cp_gate),
    .line_start(line_start), .line_valid(line_valid), .adc_sample(adc_sample),
    .pixel_index(pixel_index)
  );

  // behavioural reference: absolute line position, expected values per cycle
  int mpos = 0, mlen = MINL, mlatched = 0;
  bit mid_chg = 0, in_rst = 1, in_flush = 0, in_xfer = 0;
  int e_sh = 0, e_p1 = 0, e_p2 = 0, e_p2l = 0, e_rs = 0, e_cp = 0;
  int e_ls = 0, e_lv = 0, e_smp = 0, e_idx = 0;
  int len_q[$];
  bit chg_q[$];

  function automatic int clampl(int v);
    return (v < MINL) ? MINL : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {e_sh, e_p1, e_p2, e_p2l, e_rs, e_cp, e_ls, e_lv, e_smp, e_idx} = '0;
      mpos = 0; mlatched = int'(integ_len); mlen = clampl(mlatched);
      mid_chg = 0; in_rst = 1; len_q.delete(); chg_q.delete();
    end else begin
      in_rst = 0;
      {e_sh, e_p1, e_p2, e_p2l, e_rs, e_cp, e_ls, e_lv, e_smp, e_idx} = '0;
      in_xfer = (mpos < XFER); in_flush = 0;
      if (mpos < XFER) begin
        e_p1 = 1;
        e_sh = (mpos >= LEAD && mpos < LEAD + SHW);
      end else begin
        int rel, s, k;
        rel = mpos - XFER; s = rel % PC; k = rel / PC;
        e_p2 = (s < PC / 2); e_p1 = !e_p2; e_p2l = e_p2;
        e_rs = (s >= RSO && s < RSO + RSW);
        e_cp = (s >= CPO && s < CPO + CPW);
        if (k < NPIX) begin
          e_lv = 1; e_smp = (s == SMO); e_ls = (rel == 0); e_idx = k;
        end else in_flush = 1;
      end
      if (int'(integ_len) != mlatched) mid_chg = 1;
      if (mpos == mlen - 1) begin
        len_q.push_back(mlen); chg_q.push_back(mid_chg);
        mpos = 0; mlatched = int'(integ_len); mlen = clampl(mlatched); mid_chg = 0;
      end else mpos++;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  int cyc = 0, last_ls = -1;
  always @(negedge clk) begin
    string tc, tp, tr;
    cyc++;
    tc = in_rst ? "R1" : (in_flush ? "R10" : "R4");
    tp = in_rst ? "R1" : (in_xfer ? "R2" : tc);
    tr = in_rst ? "R1" : (in_xfer ? "R3" : (in_flush ? "R10" : "R5"));
    chk(in_rst ? "R1" : "R2", "sh_gate", int'(sh_gate), e_sh);
    chk(tp, "phi1", int'(phi1), e_p1);
    chk(tp, "phi2", int'(phi2), e_p2);
    chk(tp, "phi2_last", int'(phi2_last), e_p2l);
    chk(tr, "rs_gate", int'(rs_gate), e_rs);
    chk((in_rst || in_xfer || in_flush) ? tr : "R6", "cp_gate", int'(cp_gate), e_cp);
    chk(in_rst ? "R1" : (in_flush ? "R10" : "R8"), "line_valid", int'(line_valid), e_lv);
    chk(in_rst ? "R1" : "R8", "line_start", int'(line_start), e_ls);
    chk(in_rst ? "R1" : (in_flush ? "R10" : "R7"), "adc_sample", int'(adc_sample), e_smp);
    chk(in_rst ? "R1" : "R7", "pixel_index", int'(pixel_index), e_idx);
    if (in_rst) last_ls = -1;
    else if (line_start) begin
      if (last_ls >= 0) begin
        int el; bit ch;
        el = (len_q.size() > 0) ? len_q.pop_front() : -1;
        ch = (chg_q.size() > 0) ? chg_q.pop_front() : 1'b0;
        chk(ch ? "R11" : "R9", "line period", cyc - last_ls, el);
      end
      last_ls = cyc;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1; integ_len = '0;
    run(4);
    rst = 0;
    run(110);                 // clamped from 0 up to the minimum (R9)
    integ_len = 16'd70;       // flush tail of 20 cycles per line (R10)
    run(160);
    integ_len = 16'd58;       // mid-line change (R11)
    run(20);
    integ_len = 16'd90;
    run(200);
    rst = 1; run(3);          // reset mid-line (R1)
    rst = 0; integ_len = 16'd50;  // exactly the minimum
    run(120);
    integ_len = 16'd49;       // just below the minimum
    run(110);
    integ_len = 16'd51;
    run(60);
    integ_len = 16'd200;      // changed again inside a line (R11)
    run(300);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule